// File: doc/BRIEF.md
# Decomposable Lookup Table

This block is a 16-cell lookup table. It is split into four 2-input sub-tables of four cells each, and their results feed a small tree of 2:1 selectors. A 2-bit mode input sets two things: how the eight data inputs are steered onto the sub-table addresses, and how the selectors are driven. As a result, one configuration word can act as four separate 2-input functions, as two 3-input functions, or as one 4-input function.

The 16 truth-table bits arrive on a static configuration input. Cells 4j to 4j+3 belong to sub-table j. Each sub-table reads its cell at the index formed by its two address bits, with the higher-numbered bit as the MSB. In the combining stage, a select of 0 passes the lower-numbered sub-table and a select of 1 passes the higher-numbered one. The result is registered once, with a synchronous active-high reset. Outputs that the current mode does not use are held at 0.

Top module: `dlut_decomp`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, `dout` becomes 4'b0000 after that edge, whatever the other inputs are.
- R2: `dout` changes only at rising edges of `clk`. After an edge it shows the function of the `mode`, `cfg` and `din` values sampled at that edge, and it holds that value until the next edge.
- R3: With `mode` = 0 (four 2-input functions), each output bit `dout[j]` (j = 0..3) equals `cfg[4*j + 2*din[2*j+1] + din[2*j]]`.
- R4: With `mode` = 1 (two 3-input functions), `dout[0]` = `cfg[{din[2],din[1],din[0]}]` and `dout[2]` = `cfg[8 + {din[6],din[5],din[4]}]`. `din[3]` and `din[7]` have no effect.
- R5: With `mode` = 1, `dout[1]` and `dout[3]` are 0.
- R6: With `mode` = 2 (one 4-input function), `dout[0]` = `cfg[{din[3],din[2],din[1],din[0]}]`. `din[7:4]` have no effect.
- R7: With `mode` = 2, `dout[3:1]` are 0.
- R8: With `mode` = 3 (reserved), `dout` is 4'b0000 for every `cfg` and `din`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the output register updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the output register |
| mode | input | 2 | 0: four 2-input, 1: two 3-input, 2: one 4-input, 3: reserved |
| cfg | input | 16 | Truth-table cells; cells 4j..4j+3 belong to sub-table j |
| din | input | 8 | Data inputs; pair 2j+1:2j addresses sub-table j in mode 0 |
| dout | output | 4 | Registered function results |

## Verification
Two things can land on the same clock edge. One is a reset. The other is a set of inputs that would give a nonzero result, or a change of mode, configuration or data. The bench provokes the first case by raising reset while a mode-0 word produces all ones, and it requires zero on the following edge. It provokes the second by changing the data between edges, and it checks that the output still holds the old value before the edge and takes the new one just after it. The main sweep walks all 256 data patterns under each table entry. That sweep toggles the inputs that each mode must ignore, so a leak from them shows up as a mismatch against the bench's own index model.

// File: rtl/dlut_pkg.sv
package dlut_pkg;
  localparam int SUB_AW    = 2;
  localparam int SUB_CELLS = 1 << SUB_AW;
  localparam int SUB_NUM   = 4;
  localparam int CFG_W     = SUB_NUM * SUB_CELLS;
  localparam int DIN_W     = SUB_NUM * SUB_AW;

  typedef enum logic [1:0] {
    MODE_QUAD2   = 2'd0,
    MODE_DUAL3   = 2'd1,
    MODE_SINGLE4 = 2'd2,
    MODE_RSVD    = 2'd3
  } mode_e;

  typedef struct packed {
    logic [SUB_NUM-1:0][SUB_AW-1:0] addr;
    logic                           s0;
    logic                           s1;
    logic                           s2;
  } route_t;
endpackage

// File: rtl/dlut_sub.sv
module dlut_sub #(
  parameter int AW = 2
) (
  input  logic [(1<<AW)-1:0] cells,
  input  logic [AW-1:0]      addr,
  output logic               y
);
  assign y = cells[addr];
endmodule

// File: rtl/dlut_route.sv
module dlut_route
  import dlut_pkg::*;
(
  input  mode_e            mode,
  input  logic [DIN_W-1:0] din,
  output route_t           rt
);
  always_comb begin
    for (int j = 0; j < SUB_NUM; j++) begin
      rt.addr[j] = din[j*SUB_AW +: SUB_AW];
    end
    rt.s0 = 1'b1;
    rt.s1 = 1'b1;
    rt.s2 = 1'b1;
    case (mode)
      MODE_DUAL3: begin
        rt.addr[0] = din[1:0];
        rt.addr[1] = din[1:0];
        rt.addr[2] = din[5:4];
        rt.addr[3] = din[5:4];
        rt.s0      = din[2];
        rt.s1      = din[6];
      end
      MODE_SINGLE4: begin
        for (int j = 0; j < SUB_NUM; j++) begin
          rt.addr[j] = din[1:0];
        end
        rt.s0 = din[2];
        rt.s1 = din[2];
        rt.s2 = din[3];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dlut_combine.sv
module dlut_combine
  import dlut_pkg::*;
(
  input  mode_e              mode,
  input  logic [SUB_NUM-1:0] r,
  input  logic               s0,
  input  logic               s1,
  input  logic               s2,
  output logic [SUB_NUM-1:0] y
);
  logic p0, p1, q;

  assign p0 = s0 ? r[1] : r[0];
  assign p1 = s1 ? r[3] : r[2];
  assign q  = s2 ? p1   : p0;

  always_comb begin
    case (mode)
      MODE_QUAD2:   y = r;
      MODE_DUAL3:   y = {1'b0, p1, 1'b0, p0};
      MODE_SINGLE4: y = {3'b000, q};
      default:      y = '0;
    endcase
  end
endmodule

// File: rtl/dlut_decomp.sv
module dlut_decomp
  import dlut_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         mode,
  input  logic [CFG_W-1:0]   cfg,
  input  logic [DIN_W-1:0]   din,
  output logic [SUB_NUM-1:0] dout
);
  mode_e              mode_q;
  route_t             rt;
  logic [SUB_NUM-1:0] sub_y;
  logic [SUB_NUM-1:0] comb_y;

  assign mode_q = mode_e'(mode);

  dlut_route u_route (
    .mode (mode_q),
    .din  (din),
    .rt   (rt)
  );

  for (genvar g = 0; g < SUB_NUM; g++) begin : g_sub
    dlut_sub #(.AW(SUB_AW)) u_sub (
      .cells (cfg[g*SUB_CELLS +: SUB_CELLS]),
      .addr  (rt.addr[g]),
      .y     (sub_y[g])
    );
  end

  dlut_combine u_comb (
    .mode (mode_q),
    .r    (sub_y),
    .s0   (rt.s0),
    .s1   (rt.s1),
    .s2   (rt.s2),
    .y    (comb_y)
  );

  always_ff @(posedge clk) begin
    if (rst) dout <= '0;
    else     dout <= comb_y;
  end

  AST_RST_CLEAR: assert property (@(posedge clk) rst |=> dout == '0); // R1
  AST_DUAL_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    mode == 2'd1 |=> (dout[1] == 1'b0 && dout[3] == 1'b0)); // R5
  AST_SINGLE_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    mode == 2'd2 |=> dout[3:1] == 3'b000); // R7
  AST_SINGLE_VALUE: assert property (@(posedge clk) disable iff (rst)
    mode == 2'd2 |=> dout[0] == $past(cfg[din[3:0]])); // R6
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    mode == 2'd3 |=> dout == '0); // R8
endmodule

// File: tb/dlut_decomp_tb.sv
module dlut_decomp_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode = 2'd0;
  logic [15:0] cfg = '0;
  logic [7:0] din = '0;
  logic [3:0] dout;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dlut_decomp u_dut (
    .clk (clk), .rst (rst), .mode (mode), .cfg (cfg), .din (din), .dout (dout)
  );

  localparam logic [17:0] VEC [8] = '{
    {2'd0, 16'hA5C3}, {2'd0, 16'h6996}, {2'd1, 16'h8E17}, {2'd1, 16'hF00F},
    {2'd2, 16'h6AC1}, {2'd2, 16'hFFFE}, {2'd3, 16'hFFFF}, {2'd0, 16'h0001}
  };

  function automatic logic [3:0] model(logic [1:0] m, logic [15:0] c, logic [7:0] d);
    logic [3:0] e = '0;
    case (m)
      2'd0: for (int j = 0; j < 4; j++)
              e[j] = c[4*j + 2*int'(d[2*j+1]) + int'(d[2*j])];
      2'd1: begin
              e[0] = c[4*int'(d[2]) + 2*int'(d[1]) + int'(d[0])];
              e[2] = c[8 + 4*int'(d[6]) + 2*int'(d[5]) + int'(d[4])];
            end
      2'd2: e[0] = c[int'(d[3:0])];
      default: e = '0;
    endcase
    return e;
  endfunction

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b mode=%0d cfg=%h din=%h",
               req, act, exp, mode, cfg, din);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [3:0] e;
    @(negedge clk);
    @(negedge clk);
    chk("R1 reset state", dout, 4'b0000);
    rst = 1'b0;

    for (int v = 0; v < 8; v++) begin
      for (int d = 0; d < 256; d++) begin
        mode = VEC[v][17:16];
        cfg  = VEC[v][15:0];
        din  = 8'(d);
        e = model(mode, cfg, din);
        @(posedge clk);
        @(negedge clk);
        case (mode)
          2'd0: chk("R3", dout, e);
          2'd1: begin
                  chk("R4", dout & 4'b0101, e & 4'b0101);
                  chk("R5", dout & 4'b1010, 4'b0000);
                end
          2'd2: begin
                  chk("R6", {3'b000, dout[0]}, {3'b000, e[0]});
                  chk("R7", {1'b0, dout[3:1]}, 4'b0000);
                end
          default: chk("R8", dout, 4'b0000);
        endcase
      end
    end

    // R1: reset on the same edge as an all-ones result
    mode = 2'd0; cfg = 16'hFFFF; din = 8'h00;
    @(posedge clk); @(negedge clk);
    chk("R3 all ones", dout, 4'b1111);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R1 reset wins", dout, 4'b0000);
    @(posedge clk); @(negedge clk);
    chk("R1 reset held", dout, 4'b0000);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R1 release", dout, 4'b1111);

    // R2: output holds between edges, then follows data and cfg changes
    mode = 2'd2; cfg = 16'h0001; din = 8'h00;
    @(posedge clk); @(negedge clk);
    chk("R2 load", dout, 4'b0001);
    din = 8'h01;
    #1;
    chk("R2 hold before edge", dout, 4'b0001);
    @(posedge clk); @(negedge clk);
    chk("R2 data update", dout, 4'b0000);
    cfg = 16'h0002;
    #1;
    chk("R2 hold cfg", dout, 4'b0000);
    @(posedge clk); @(negedge clk);
    chk("R2 cfg update", dout, 4'b0001);
    mode = 2'd3;
    @(posedge clk); @(negedge clk);
    chk("R8 mode switch", dout, 4'b0000);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule